// File: doc/BRIEF.md
# Pipelined (8,4) Polar Code Decoder

This block decodes an (8,4) polar code with a feed-forward pipeline. The full decoding tree is flattened into a chain of dedicated stages, so every operation has its own hardware. A frame of eight signed fixed-point log-likelihood ratios (LLRs) enters with a valid strobe, and a new frame can enter on every clock. Earlier frames move forward one stage per clock.

The decoder does not work through the bits one at a time. The left half of the code is handled as a repetition subcode and the right half as a single-parity-check subcode. The pipeline has five stages:

1. A min-sum combine of LLR pairs across the two halves.
2. The repetition decision.
3. A combine that uses the repetition decision to correct the right-half LLRs.
4. The parity-check decision.
5. A final XOR combine of the partial sums.

The block returns the hard-decision 8-bit codeword and the four information bits. A valid strobe marks them, and it arrives a fixed five cycles after the matching input strobe.

Top module: `polar_unrolled_dec`

## Requirements
- R1: LLR lane i (0..7) sits at `llrIn[i*LLR_W +: LLR_W]` in two's complement. A positive value favours bit 0, and a new frame is accepted in every cycle that `inValid` is high.
- R2: The first stage makes, for each i in 0..3, the value sign(y[i])·sign(y[i+4])·min(|y[i]|,|y[i+4]|). The magnitude is limited to 2^(LLR_W-1)-1, so the most negative input code acts as the largest positive magnitude.
- R3: The repetition decision adds the four first-stage values. A negative sum sets all four left bits v[0..3] to 1. A zero or positive sum sets them all to 0.
- R4: The right-half LLR for lane i is y[i+4]+y[i] when v[i]=0 and y[i+4]-y[i] when v[i]=1. The result is saturated to ±(2^(LLR_W-1)-1).
- R5: The parity-check decision first takes w[i]=1 for a negative LLR and 0 otherwise. If the four decisions have odd parity, it inverts the bit with the smallest LLR magnitude. On a tie in magnitude, the lowest index is inverted.
- R6: The output is laid out as `cwOut[i]=v[i]^w[i]` and `cwOut[i+4]=w[i]` for i in 0..3. The information bits are `infoOut[0]=v[0]`, `infoOut[1]=w[1]^w[3]`, `infoOut[2]=w[2]^w[3]` and `infoOut[3]=w[3]`.
- R7: `outValid` is high exactly five cycles after each cycle with `inValid` high, and only then. Frames come out in the order they went in, at up to one per clock.
- R8: While `rstN` is low, and after it is released until the first frame has passed through the pipeline, `outValid` stays low.
- R9: Any codeword built from a 4-bit message, with frozen bits u0, u1, u2, u4 equal to zero and mapped to ±A LLRs, decodes back to that message and that codeword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks a frame on `llrIn` |
| llrIn | input | 8*LLR_W | Eight packed channel LLRs |
| outValid | output | 1 | Marks a decoded frame |
| cwOut | output | 8 | Hard-decision codeword |
| infoOut | output | 4 | Decoded information bits |

## Verification
The assertions check four things on every cycle:
- the five-cycle tie between the input and output strobes;
- that every emitted codeword has an even-parity right half;
- that its two halves differ by all zeros or all ones;
- that the information bits follow the codeword through the R6 mapping.

Only the bench's scenarios can show the arithmetic itself:
- saturation of the min-sum and sum-difference steps at the extreme codes;
- the zero-sum repetition decision;
- the parity-check correction, including the lowest-index tie rule;
- full-message recovery over every message, both back-to-back and with gaps.

// File: rtl/polar_pkg.sv
package polar_pkg;
  localparam int CODE_N = 8;
  localparam int INFO_K = 4;
  localparam int PIPE_STAGES = 5;

  typedef struct packed {
    logic [PIPE_STAGES-1:0] stageEn;
    logic                   outValid;
  } ctrl_t;
endpackage

// File: rtl/polar_ctrl.sv
module polar_ctrl
  import polar_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  output ctrl_t strobe
);
  logic [PIPE_STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[PIPE_STAGES-2:0], inValid};
  end

  always_comb begin
    strobe.stageEn    = {validPipe[PIPE_STAGES-2:0], inValid};
    strobe.outValid   = validPipe[PIPE_STAGES-1];
  end
endmodule

// File: rtl/polar_dp.sv
module polar_dp
  import polar_pkg::*;
#(
  parameter int LLR_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_t                   strobe,
  input  logic [CODE_N*LLR_W-1:0] llrIn,
  output logic [CODE_N-1:0]       cwOut,
  output logic [INFO_K-1:0]       infoOut
);
  localparam int HALF = CODE_N / 2;
  localparam int IDX_W = $clog2(HALF);
  localparam int LMAX = 2 ** (LLR_W - 1) - 1;
  localparam logic signed [LLR_W+1:0] WMAX = LMAX;
  localparam logic signed [LLR_W+1:0] WMIN = -LMAX;

  typedef logic signed [LLR_W-1:0] llr_t;
  typedef logic signed [LLR_W+1:0] wide_t;

  function automatic wide_t widen(input llr_t a);
    return {{2{a[LLR_W-1]}}, a};
  endfunction

  function automatic wide_t magOf(input llr_t a);
    return a[LLR_W-1] ? -widen(a) : widen(a);
  endfunction

  function automatic llr_t satNarrow(input wide_t x);
    if (x > WMAX) return WMAX[LLR_W-1:0];
    if (x < WMIN) return WMIN[LLR_W-1:0];
    return x[LLR_W-1:0];
  endfunction

  function automatic llr_t minSum(input llr_t a, input llr_t b);
    wide_t ma, mb;
    llr_t  ms;
    ma = magOf(a);
    mb = magOf(b);
    ms = satNarrow((ma < mb) ? ma : mb);
    return (a[LLR_W-1] ^ b[LLR_W-1]) ? -ms : ms;
  endfunction

  function automatic llr_t sumDiff(input llr_t a, input llr_t b, input logic uBit);
    return satNarrow(uBit ? (widen(b) - widen(a)) : (widen(b) + widen(a)));
  endfunction

  llr_t yIn [CODE_N];
  for (genvar i = 0; i < CODE_N; i++) begin : g_unpack
    assign yIn[i] = llrIn[i*LLR_W +: LLR_W];
  end

  // Stage 1: min-sum combine
  llr_t s1Alpha [HALF];
  llr_t s1Y [CODE_N];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HALF; i++) s1Alpha[i] <= '0;
      for (int i = 0; i < CODE_N; i++) s1Y[i] <= '0;
    end else if (strobe.stageEn[0]) begin
      for (int i = 0; i < HALF; i++) s1Alpha[i] <= minSum(yIn[i], yIn[i+HALF]);
      for (int i = 0; i < CODE_N; i++) s1Y[i] <= yIn[i];
    end
  end

  // Stage 2: repetition decision
  wide_t repSum;
  always_comb begin
    repSum = '0;
    for (int i = 0; i < HALF; i++) repSum = repSum + widen(s1Alpha[i]);
  end

  logic [HALF-1:0] s2V;
  llr_t s2Y [CODE_N];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2V <= '0;
      for (int i = 0; i < CODE_N; i++) s2Y[i] <= '0;
    end else if (strobe.stageEn[1]) begin
      s2V <= {HALF{repSum[LLR_W+1]}};
      for (int i = 0; i < CODE_N; i++) s2Y[i] <= s1Y[i];
    end
  end

  // Stage 3: partial-sum guided combine
  llr_t s3Beta [HALF];
  logic [HALF-1:0] s3V;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s3V <= '0;
      for (int i = 0; i < HALF; i++) s3Beta[i] <= '0;
    end else if (strobe.stageEn[2]) begin
      s3V <= s2V;
      for (int i = 0; i < HALF; i++) s3Beta[i] <= sumDiff(s2Y[i], s2Y[i+HALF], s2V[i]);
    end
  end

  // Stage 4: parity-check decision
  logic [HALF-1:0] hardBits;
  logic [HALF-1:0] flipMask;
  logic [IDX_W-1:0] minIdx;
  wide_t minMag;
  always_comb begin
    minIdx = '0;
    minMag = magOf(s3Beta[0]);
    for (int i = 0; i < HALF; i++) begin
      hardBits[i] = s3Beta[i][LLR_W-1];
      if (magOf(s3Beta[i]) < minMag) begin
        minMag = magOf(s3Beta[i]);
        minIdx = IDX_W'(i);
      end
    end
    flipMask = '0;
    if (^hardBits) flipMask[minIdx] = 1'b1;
  end

  logic [HALF-1:0] s4W, s4V;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s4W <= '0;
      s4V <= '0;
    end else if (strobe.stageEn[3]) begin
      s4W <= hardBits ^ flipMask;
      s4V <= s3V;
    end
  end

  // Stage 5: partial-sum XOR combine and bit extraction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cwOut   <= '0;
      infoOut <= '0;
    end else if (strobe.stageEn[4]) begin
      cwOut   <= {s4W, s4V ^ s4W};
      infoOut <= {s4W[3], s4W[2] ^ s4W[3], s4W[1] ^ s4W[3], s4V[0]};
    end
  end
endmodule

// File: rtl/polar_unrolled_dec.sv
module polar_unrolled_dec
  import polar_pkg::*;
#(
  parameter int LLR_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [CODE_N*LLR_W-1:0] llrIn,
  output logic                    outValid,
  output logic [CODE_N-1:0]       cwOut,
  output logic [INFO_K-1:0]       infoOut
);
  ctrl_t strobe;

  polar_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe)
  );

  polar_dp #(.LLR_W(LLR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .llrIn   (llrIn),
    .cwOut   (cwOut),
    .infoOut (infoOut)
  );

  assign outValid = strobe.outValid;
endmodule

// File: rtl/polar_dec_chk.sv
module polar_dec_chk
  import polar_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              outValid,
  input logic [CODE_N-1:0] cwOut,
  input logic [INFO_K-1:0] infoOut
);
  int sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= 0;
    else if (sinceRst < PIPE_STAGES) sinceRst <= sinceRst + 1;
  end

  // R7, R8: output strobe follows input strobe by a fixed five cycles
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= PIPE_STAGES) |-> (outValid == $past(inValid, 5)));

  // R5: the right half of every emitted codeword has even parity
  assert_even_parity_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (^cwOut[7:4] == 1'b0));

  // R3: halves differ by an all-equal repetition pattern
  assert_rep_pattern_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((cwOut[3:0] ^ cwOut[7:4]) == 4'h0 || (cwOut[3:0] ^ cwOut[7:4]) == 4'hF));

  // R6: information bits agree with the codeword
  assert_info_map_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (infoOut == {cwOut[7], cwOut[6] ^ cwOut[7], cwOut[5] ^ cwOut[7], cwOut[0] ^ cwOut[4]}));
endmodule

bind polar_unrolled_dec polar_dec_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .cwOut    (cwOut),
  .infoOut  (infoOut)
);

// File: tb/test_polar_unrolled_dec.sv
module test_polar_unrolled_dec;
  localparam int W = 6;
  localparam int N = 8;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rstN;
  logic inValid;
  logic [N*W-1:0] llrIn;
  logic outValid;
  logic [7:0] cwOut;
  logic [3:0] infoOut;

  polar_unrolled_dec #(.LLR_W(W)) i_polar_unrolled_dec (
    .clk(clk), .rstN(rstN), .inValid(inValid), .llrIn(llrIn),
    .outValid(outValid), .cwOut(cwOut), .infoOut(infoOut)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  logic [7:0] expCw [0:511];
  logic [3:0] expInfo [0:511];
  int expCyc [0:511];
  string expTag [0:511];
  int wrIdx = 0;
  int rdIdx = 0;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] encode(input logic [3:0] m);
    logic [3:0] v, w;
    v = {4{m[0]}};
    w[0] = m[1] ^ m[2] ^ m[3];
    w[1] = m[1] ^ m[3];
    w[2] = m[2] ^ m[3];
    w[3] = m[3];
    return {w, v ^ w};
  endfunction

  function automatic logic [N*W-1:0] mkLlr(input logic [7:0] cw, input int amp);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = cw[i] ? W'(-amp) : W'(amp);
    return r;
  endfunction

  task automatic send(input logic [N*W-1:0] v, input logic [7:0] ecw,
                      input logic [3:0] einf, input string tg);
    inValid = 1'b1;
    llrIn = v;
    expCw[wrIdx] = ecw;
    expInfo[wrIdx] = einf;
    expCyc[wrIdx] = cyc;
    expTag[wrIdx] = tg;
    wrIdx++;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid) begin
      if (rdIdx >= wrIdx) begin
        chk("R7 unexpected outValid", 1'b0, 1, 0);
      end else begin
        chk({expTag[rdIdx], " codeword"}, cwOut == expCw[rdIdx], cwOut, expCw[rdIdx]);
        chk({expTag[rdIdx], " info bits"}, infoOut == expInfo[rdIdx], infoOut, expInfo[rdIdx]);
        chk("R7 latency", (cyc - expCyc[rdIdx]) == LAT, cyc - expCyc[rdIdx], LAT);
        rdIdx++;
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] v;
    rstN = 1'b0;
    inValid = 1'b0;
    llrIn = '0;
    repeat (3) @(negedge clk);
    chk("R8 outValid in reset", outValid == 1'b0, outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 outValid after reset", outValid == 1'b0, outValid, 0);

    // R9, R1, R7: all messages back to back, noiseless amplitude 20
    for (int m = 0; m < 16; m++) send(mkLlr(encode(4'(m)), 20), encode(4'(m)), 4'(m), "R9 noiseless");

    // R4: amplitude 31 makes the sum step exceed the range and saturate
    for (int m = 0; m < 16; m++) send(mkLlr(encode(4'(m)), 31), encode(4'(m)), 4'(m), "R4 saturated sum");

    // R5: weak flips in both halves of one lane; parity check must correct
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] c;
        c = encode(4'(m));
        v = mkLlr(c, 20);
        v[p*W +: W] = c[p] ? W'(2) : W'(-2);
        v[(p+4)*W +: W] = c[p+4] ? W'(2) : W'(-2);
        send(v, c, 4'(m), "R5 parity correction");
        if (p[0]) @(negedge clk);
      end
    end

    // R3: all-zero LLRs give a zero sum, decided as 0
    send('0, 8'h00, 4'h0, "R3 zero sum");

    // R2: most negative code in every lane, magnitude saturates to 31
    v = '0;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(-32);
    send(v, 8'hFF, 4'b1000, "R2 min-sum saturation");

    // R5: tie between lanes 0 and 1 at magnitude 3, lowest index is flipped
    v = '0;
    v[0*W +: W] = W'(20);  v[4*W +: W] = W'(-23);
    v[1*W +: W] = W'(20);  v[5*W +: W] = W'(-17);
    v[2*W +: W] = W'(20);  v[6*W +: W] = W'(20);
    v[3*W +: W] = W'(20);  v[7*W +: W] = W'(20);
    send(v, 8'h00, 4'h0, "R5 tie lowest index");

    repeat (LAT + 4) @(negedge clk);
    chk("R7 every frame delivered", rdIdx == wrIdx, rdIdx, wrIdx);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule